// File: doc/BRIEF.md
# Redundant Controller Copy Guard

This block sits inside each of two identical controller copies that share one converter gate drive. Each copy reports whether it is healthy through a one-bit status line and watches the same line from its partner. If the partner stays unhealthy for longer than a programmable number of clocks, the copy asks for the partner to be reconfigured. It raises that request only while the copy itself is healthy, so a copy that is recovering can never force its partner down.

While its own reconfiguration is running, a copy releases the gate drive by dropping its output enable. When reconfiguration finishes, the copy clears its control state. It then waits for the partner's next PWM period start and takes the partner's duty word at that point. It pulses a load strobe for one cycle and only after that takes the drive again, so the working copy carries the loop on its own the whole time. A mode input selects the alternative recovery instead. In that mode the recovered copy starts from a zero duty word, and the healthy copy restarts its own loop when the partner comes back. This mode exists to compare the two ways of recovering.

Top module: `redundant_copy_guard`

## Requirements
- R1: After reset is released, `self_online` and `drive_en` are 1, and `peer_reconfig_req`, `load_strobe` and `loop_restart` are 0. `load_duty` is 0.
- R2: `peer_reconfig_req` rises after `peer_online` has been sampled low on TIMEOUT_CYC consecutive clock edges. It is not raised after TIMEOUT_CYC-1 such edges, and it stays high while the peer remains offline.
- R3: One clock edge that samples `peer_online` high restarts the offline count from zero, and `peer_reconfig_req` is low after that edge.
- R4: An edge that samples `upset_detect` high while the copy is online or resynchronising moves the copy offline. After that edge `self_online` and `drive_en` are 0, and they stay 0 until a recovery completes.
- R5: An edge that samples `reconfig_active` high moves the copy into reconfiguration from any state, including online. `drive_en` and `self_online` are 0 after that edge and stay 0 while the flag is high. The flag takes priority over `upset_detect`.
- R6: The edge that samples `reconfig_active` low at the end of reconfiguration clears `load_duty` to 0. The copy then holds `drive_en` and `load_strobe` at 0 until an edge samples `peer_period_start` high.
- R7: With `restart_mode` = 0, the edge that samples `peer_period_start` high during resynchronisation stores `peer_duty` into `load_duty`. `load_strobe` is 1 for exactly the following cycle, with `drive_en` still 0. One edge later `drive_en` and `self_online` are 1 and `load_strobe` is 0.
- R8: With `restart_mode` = 1, the same capture edge stores 0 into `load_duty` and ignores `peer_duty`. The strobe and enable timing is the same as in R7.
- R9: With `restart_mode` = 1, a healthy copy that has held `peer_reconfig_req` high for at least one edge gives a one-cycle `loop_restart` pulse. The pulse follows the first edge that samples `peer_online` high again. With `restart_mode` = 0 `loop_restart` stays 0.
- R10: `peer_reconfig_req` is 0 whenever the copy is not online, even after the timeout has expired. If the peer is still offline when the copy comes back online, the request appears in the first online cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| peer_online | input | 1 | Partner copy's status, 1 = healthy |
| peer_duty | input | DUTY_W | Partner copy's live duty word |
| peer_period_start | input | 1 | Partner's PWM period boundary, one-cycle pulse |
| reconfig_active | input | 1 | This copy is being reconfigured |
| upset_detect | input | 1 | This copy has detected an upset in itself |
| restart_mode | input | 1 | 0 = copy state from partner, 1 = restart both loops |
| self_online | output | 1 | This copy's status, 1 = healthy |
| peer_reconfig_req | output | 1 | Request that the partner be reconfigured |
| drive_en | output | 1 | Gate driver enable, 0 = high impedance |
| load_strobe | output | 1 | One-cycle strobe: `load_duty` is valid to load |
| load_duty | output | DUTY_W | Duty word for the local controller to load |
| loop_restart | output | 1 | One-cycle pulse telling the local loop to restart |

## Verification
The hardest situation to reach is a copy that is offline or recovering while its partner has also been offline past the timeout. Here the request must stay suppressed and then appear on the first online cycle. The bench reaches it by holding `peer_online` low across a full local upset, reconfiguration and resynchronisation sequence. Capture timing is checked with sweeps: the number of offline edges is swept across the timeout, and the recovery is repeated with many duty words and different waits before the period start.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef enum logic [1:0] {
    CS_ONLINE   = 2'd0,
    CS_OFFLINE  = 2'd1,
    CS_RECONFIG = 2'd2,
    CS_RESYNC   = 2'd3
  } copy_state_e;
endpackage

// File: rtl/rcg_rst_sync.sv
module rcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/rcg_peer_watch.sv
module rcg_peer_watch #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic peer_online_i,
  input  logic self_online_i,
  input  logic restart_mode_i,
  output logic req_o,
  output logic restart_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             expired;
  logic             decl_q, decl_d;
  logic             restart_q, restart_d;

  assign expired = (cnt_q == CNT_MAX);
  assign req_o   = expired && self_online_i;

  // offline counter: clears on any online sample, saturates at the limit
  always_comb begin
    cnt_en = peer_online_i || !expired;
    cnt_d  = cnt_q;
    if (peer_online_i) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  // remembers that a request was raised until the peer returns
  always_comb begin
    decl_d = decl_q;
    if (peer_online_i) decl_d = 1'b0;
    else if (req_o)    decl_d = 1'b1;
    restart_d = restart_mode_i && decl_q && peer_online_i && self_online_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      decl_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      decl_q    <= decl_d;
      restart_q <= restart_d;
    end
  end

  assign restart_o = restart_q;

  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_req_after_offline_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !$past(peer_online_i));
  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    peer_online_i |=> (cnt_q == '0));
  p_restart_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |=> !restart_q);
  p_restart_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> $past(restart_mode_i));
endmodule

// File: rtl/rcg_copy_fsm.sv
module rcg_copy_fsm
  import rcg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reconfig_active_i,
  input  logic        upset_i,
  input  logic        period_start_i,
  input  logic        loaded_i,
  input  logic        req_i,
  output copy_state_e state_o,
  output logic        capture_o,
  output logic        clear_o
);
  copy_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (reconfig_active_i) begin
      state_d = CS_RECONFIG;
    end else begin
      case (state_q)
        CS_ONLINE:   if (upset_i) state_d = CS_OFFLINE;
        CS_OFFLINE:  state_d = CS_OFFLINE;
        CS_RECONFIG: state_d = CS_RESYNC;
        CS_RESYNC: begin
          if (upset_i)       state_d = CS_OFFLINE;
          else if (loaded_i) state_d = CS_ONLINE;
        end
        default:     state_d = CS_OFFLINE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_ONLINE;
    else        state_q <= state_d;
  end

  assign capture_o = (state_q == CS_RESYNC) && !reconfig_active_i && !upset_i
                     && !loaded_i && period_start_i;
  assign clear_o   = (state_q == CS_RECONFIG) && !reconfig_active_i;
  assign state_o   = state_q;

  p_reconfig_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_active_i |=> (state_q == CS_RECONFIG));
  p_upset_offline_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upset_i && !reconfig_active_i && (state_q == CS_ONLINE)) |=> (state_q == CS_OFFLINE));
  p_no_req_recovering_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CS_ONLINE) |-> !req_i);
  p_resync_after_reconfig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> (state_q == CS_RESYNC));
endmodule

// File: rtl/rcg_state_loader.sv
module rcg_state_loader #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              clear_i,
  input  logic              restart_mode_i,
  input  logic [DUTY_W-1:0] peer_duty_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              strobe_o
);
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              duty_en;
  logic              strobe_q;

  always_comb begin
    duty_en = clear_i || capture_i;
    if (clear_i || restart_mode_i) duty_d = '0;
    else                           duty_d = peer_duty_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (duty_en) duty_q <= duty_d;
      strobe_q <= capture_i;
    end
  end

  assign duty_o   = duty_q;
  assign strobe_o = strobe_q;

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  p_capture_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !restart_mode_i) |=> (duty_q == $past(peer_duty_i)));
  p_capture_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && restart_mode_i) |=> (duty_q == '0));
  p_clear_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (duty_q == '0));
endmodule

// File: rtl/redundant_copy_guard.sv
module redundant_copy_guard
  import rcg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024,
  parameter int DUTY_W      = 8,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peer_online,
  input  logic [DUTY_W-1:0] peer_duty,
  input  logic              peer_period_start,
  input  logic              reconfig_active,
  input  logic              upset_detect,
  input  logic              restart_mode,
  output logic              self_online,
  output logic              peer_reconfig_req,
  output logic              drive_en,
  output logic              load_strobe,
  output logic [DUTY_W-1:0] load_duty,
  output logic              loop_restart
);
  logic        rst_n_int;
  copy_state_e state;
  logic        capture;
  logic        clear;
  logic        online_st;
  logic        req;

  rcg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  assign online_st = (state == CS_ONLINE);

  rcg_peer_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .peer_online_i  (peer_online),
    .self_online_i  (online_st),
    .restart_mode_i (restart_mode),
    .req_o          (req),
    .restart_o      (loop_restart)
  );

  rcg_copy_fsm u_fsm (
    .clk               (clk),
    .rst_n             (rst_n_int),
    .reconfig_active_i (reconfig_active),
    .upset_i           (upset_detect),
    .period_start_i    (peer_period_start),
    .loaded_i          (load_strobe),
    .req_i             (req),
    .state_o           (state),
    .capture_o         (capture),
    .clear_o           (clear)
  );

  rcg_state_loader #(.DUTY_W(DUTY_W)) u_load (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .capture_i      (capture),
    .clear_i        (clear),
    .restart_mode_i (restart_mode),
    .peer_duty_i    (peer_duty),
    .duty_o         (load_duty),
    .strobe_o       (load_strobe)
  );

  assign self_online       = online_st;
  assign drive_en          = online_st;
  assign peer_reconfig_req = req;

  p_strobe_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    load_strobe |-> !drive_en);
  p_strobe_then_enable_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_strobe && !reconfig_active && !upset_detect) |=> drive_en);
  p_reconfig_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    reconfig_active |=> !drive_en);
endmodule

// File: tb/redundant_copy_guard_tb_top.sv
module redundant_copy_guard_tb_top;
  localparam int TO = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          peer_online, peer_period_start, reconfig_active, upset_detect, restart_mode;
  logic [DW-1:0] peer_duty;
  logic          self_online, peer_reconfig_req, drive_en, load_strobe, loop_restart;
  logic [DW-1:0] load_duty;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  redundant_copy_guard #(.TIMEOUT_CYC(TO), .DUTY_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .peer_online(peer_online), .peer_duty(peer_duty),
    .peer_period_start(peer_period_start), .reconfig_active(reconfig_active),
    .upset_detect(upset_detect), .restart_mode(restart_mode),
    .self_online(self_online), .peer_reconfig_req(peer_reconfig_req),
    .drive_en(drive_en), .load_strobe(load_strobe), .load_duty(load_duty),
    .loop_restart(loop_restart)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // full recovery of this copy; expects drive/strobe/duty per R4..R8
  task automatic recover(input logic via_upset, input logic [DW-1:0] v,
                         input int waits, input logic mode);
    restart_mode = mode;
    if (via_upset) begin
      upset_detect = 1'b1; tick();
      upset_detect = 1'b0;
      chk(self_online, 0, "R4 offline status");
      chk(drive_en, 0, "R4 drive released");
      tick(2);
      chk(drive_en, 0, "R4 stays offline");
    end
    reconfig_active = 1'b1; upset_detect = 1'b1; tick();
    upset_detect = 1'b0;
    chk(drive_en, 0, "R5 hiz in reconfig");
    chk(self_online, 0, "R5 status in reconfig");
    tick(2);
    chk(drive_en, 0, "R5 hiz held");
    reconfig_active = 1'b0; tick();
    chk(load_duty, 0, "R6 duty cleared");
    chk(drive_en, 0, "R6 waiting no drive");
    for (int w = 0; w < waits; w++) begin
      tick();
      chk(load_strobe, 0, "R6 no strobe before boundary");
      chk(drive_en, 0, "R6 no drive before boundary");
    end
    peer_duty = v; peer_period_start = 1'b1; tick();
    peer_period_start = 1'b0; peer_duty = ~v;
    chk(load_strobe, 1, mode ? "R8 strobe" : "R7 strobe");
    chk(drive_en, 0, mode ? "R8 drive off at strobe" : "R7 drive off at strobe");
    chk(load_duty, mode ? 0 : v, mode ? "R8 zero word" : "R7 copied word");
    tick();
    chk(load_strobe, 0, "R7 strobe one cycle");
    chk(drive_en, 1, "R7 drive after strobe");
    chk(self_online, 1, "R7 online after strobe");
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; peer_online = 1'b1; peer_duty = '0; peer_period_start = 1'b0;
    reconfig_active = 1'b0; upset_detect = 1'b0; restart_mode = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1
    chk(self_online, 1, "R1 online");
    chk(drive_en, 1, "R1 drive");
    chk(peer_reconfig_req, 0, "R1 req");
    chk(load_strobe, 0, "R1 strobe");
    chk(load_duty, 0, "R1 duty");
    chk(loop_restart, 0, "R1 restart");

    // R2 sweep of offline lengths across the timeout
    for (int n = 1; n <= TO + 4; n++) begin
      peer_online = 1'b0; tick(n);
      chk(peer_reconfig_req, (n >= TO) ? 1 : 0, "R2 timeout sweep");
      peer_online = 1'b1; tick();
      chk(peer_reconfig_req, 0, "R3 req drops on online");
    end

    // R3 a single online sample restarts the count
    peer_online = 1'b0; tick(TO - 1);
    peer_online = 1'b1; tick();
    peer_online = 1'b0; tick(TO - 1);
    chk(peer_reconfig_req, 0, "R3 count restarted");
    tick();
    chk(peer_reconfig_req, 1, "R3 full run");
    peer_online = 1'b1; tick();

    // R4..R7 recovery sweep, copy mode
    for (int k = 0; k < 16; k++) begin
      recover(k[0] == 1'b0, DW'((k * 37 + 11) % 256), k % 3, 1'b0);
      tick();
    end

    // R8 restart mode: zero word
    recover(1'b1, 8'hA5, 1, 1'b1);
    tick();

    // R9 restart pulse on peer return
    restart_mode = 1'b1;
    peer_online = 1'b0; tick(TO + 1);
    chk(loop_restart, 0, "R9 no pulse while peer offline");
    peer_online = 1'b1; tick();
    chk(loop_restart, 1, "R9 pulse on return");
    tick();
    chk(loop_restart, 0, "R9 pulse one cycle");
    restart_mode = 1'b0;
    peer_online = 1'b0; tick(TO + 1);
    peer_online = 1'b1; tick();
    chk(loop_restart, 0, "R9 no pulse in copy mode");
    tick();
    chk(loop_restart, 0, "R9 no pulse in copy mode later");

    // R10 request suppressed while recovering
    peer_online = 1'b0;
    upset_detect = 1'b1; tick();
    upset_detect = 1'b0;
    tick(TO + 2);
    chk(peer_reconfig_req, 0, "R10 no req offline");
    reconfig_active = 1'b1; tick(2);
    chk(peer_reconfig_req, 0, "R10 no req reconfig");
    reconfig_active = 1'b0; tick();
    chk(peer_reconfig_req, 0, "R10 no req resync");
    peer_duty = 8'h3C; peer_period_start = 1'b1; tick();
    peer_period_start = 1'b0;
    chk(peer_reconfig_req, 0, "R10 no req at strobe");
    chk(load_duty, 8'h3C, "R7 copy with peer offline");
    tick();
    chk(peer_reconfig_req, 1, "R10 req once online");
    peer_online = 1'b1; tick();
    chk(peer_reconfig_req, 0, "R10 req drops");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule